// File: doc/BRIEF.md
# Vectored Interrupt Controller with Acknowledge

This block collects a set of level-sensitive interrupt sources and presents them to a single processor. Each source carries two pieces of state: an enable bit held in a global register region and an unmask bit held in a per-CPU register region. Software never rewrites a bitmap. It writes a source number to a dedicated register, and that one write sets or clears the matching bit.

A source qualifies when its input is high, it is enabled and it is unmasked. The interrupt output is high while any source qualifies. The processor reads the acknowledge register to learn which source to service, and it keeps reading until the acknowledge register returns the spurious code 1023.

Reading the acknowledge register has no side effect. A source whose line is still high is reported again on the next read. The block has a write port and a read port. Both address a 13-bit space in which bit 12 selects the per-CPU region and bits 11:0 give the offset within the region.

Top module: `vic_ack_top`

## Requirements
- R1: After reset every source is disabled and masked, `irq` is low, `rdValid` is low, and an acknowledge read returns 1023.
- R2: Writing a source number to global offset 0xA30 (address bit 12 = 0) enables that source.
- R3: Writing a source number to global offset 0xA34 (address bit 12 = 0) disables that source.
- R4: Writing a source number to per-CPU offset 0xBC (address bit 12 = 1) unmasks that source.
- R5: Writing a source number to per-CPU offset 0xB8 (address bit 12 = 1) masks that source.
- R6: A read request is answered on the next cycle, with `rdValid` high for exactly that cycle. For per-CPU offset 0xB4 the source ID is in `rdData[9:0]` and bits 31:10 are zero. A read of any other address returns zero.
- R7: When no source is high, enabled and unmasked, the acknowledge read returns 1023.
- R8: When several sources qualify, the acknowledge read returns the lowest-numbered one.
- R9: An acknowledge read does not clear anything. A source whose line is still high is returned again by the next read.
- R10: `irq` is high exactly when at least one source is high, enabled and unmasked.
- R11: A write whose source number is not below NUM_SRC changes no state. This includes 1023 and any value whose low bits alias a real source.
- R12: A write to an enable offset in the per-CPU region, or to a mask offset in the global region, changes no state.
- R13: When an acknowledge read and a mask or enable write fall in the same cycle, the read reports the state from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | NUM_SRC | Level-sensitive source lines, bit n is source n |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 13 | Write address, bit 12 selects the per-CPU region |
| wrData | input | 32 | Write data, bits 9:0 carry the source number |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 13 | Read address |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| rdData | output | 32 | Read data |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The write port and the read port are independent, so a mask or enable write can land on the same clock edge as an acknowledge read. The bench provokes this by raising both strobes in one cycle: it unmasks a lower-numbered source while a higher-numbered one is being reported. It judges the result by requiring the colliding read to return the old winner and a read issued one cycle later to return the new one. A change on a source line coinciding with a read is covered the same way, because the reported ID is taken from the lines as they stand at that edge.

// File: rtl/vic_ack_pkg.sv
package vic_ack_pkg;

  localparam int ID_W   = 10;
  localparam int OFF_W  = 12;
  localparam int ADDR_W = OFF_W + 1;
  localparam int DATA_W = 32;

  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  // Offsets inside the global region
  localparam logic [OFF_W-1:0] OFF_EN_SET = 12'hA30;
  localparam logic [OFF_W-1:0] OFF_EN_CLR = 12'hA34;
  // Offsets inside the per-CPU region
  localparam logic [OFF_W-1:0] OFF_UNMASK = 12'h0BC;
  localparam logic [OFF_W-1:0] OFF_MASK   = 12'h0B8;
  localparam logic [OFF_W-1:0] OFF_ACK    = 12'h0B4;

  typedef enum logic {
    REGION_GLOBAL = 1'b0,
    REGION_CPU    = 1'b1
  } region_e;

  typedef struct packed {
    logic            enSet;
    logic            enClr;
    logic            unmaskSet;
    logic            maskSet;
    logic [ID_W-1:0] srcId;
  } ctrlStrobe_t;

endpackage

// File: rtl/vic_ack_ctrl.sv
module vic_ack_ctrl
  import vic_ack_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ID_W-1:0]   winnerId,
  input  logic              irqIn,
  output ctrlStrobe_t       stb,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  region_e          wrRegion;
  region_e          rdRegion;
  logic [OFF_W-1:0] wrOff;
  logic [OFF_W-1:0] rdOff;
  logic             ackHit;

  assign wrRegion = region_e'(wrAddr[ADDR_W-1]);
  assign rdRegion = region_e'(rdAddr[ADDR_W-1]);
  assign wrOff    = wrAddr[OFF_W-1:0];
  assign rdOff    = rdAddr[OFF_W-1:0];
  assign ackHit   = rdEn && (rdRegion == REGION_CPU) && (rdOff == OFF_ACK);

  always_comb begin
    stb           = '0;
    stb.srcId     = wrData[ID_W-1:0];
    if (wrEn) begin
      unique case (wrRegion)
        REGION_GLOBAL: begin
          stb.enSet = (wrOff == OFF_EN_SET);
          stb.enClr = (wrOff == OFF_EN_CLR);
        end
        REGION_CPU: begin
          stb.unmaskSet = (wrOff == OFF_UNMASK);
          stb.maskSet   = (wrOff == OFF_MASK);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) begin
        rdData <= ackHit ? {{(DATA_W-ID_W){1'b0}}, winnerId} : '0;
      end
    end
  end

  // R6: answer arrives exactly one cycle after the request
  a_r6_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);
  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);
  // R6: upper bits of returned data are zero
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdData[DATA_W-1:ID_W] == '0));
  // R7: nothing qualifying means the spurious code is reported
  a_r7_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (ackHit && !irqIn) |=> (rdData[ID_W-1:0] == SPURIOUS_ID));

endmodule

// File: rtl/vic_ack_datapath.sv
module vic_ack_datapath
  import vic_ack_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  ctrlStrobe_t        stb,
  output logic [ID_W-1:0]    winnerId,
  output logic               irq
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] enBits;
  logic [NUM_SRC-1:0] unmaskBits;
  logic [NUM_SRC-1:0] qualBits;
  logic               idOk;
  logic [IDX_W-1:0]   idx;
  logic               anyWr;

  assign idOk  = (32'(stb.srcId) < NUM_SRC);
  assign idx   = stb.srcId[IDX_W-1:0];
  assign anyWr = stb.enSet | stb.enClr | stb.unmaskSet | stb.maskSet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBits     <= '0;
      unmaskBits <= '0;
    end else if (idOk) begin
      if (stb.enSet)     enBits[idx]     <= 1'b1;
      if (stb.enClr)     enBits[idx]     <= 1'b0;
      if (stb.unmaskSet) unmaskBits[idx] <= 1'b1;
      if (stb.maskSet)   unmaskBits[idx] <= 1'b0;
    end
  end

  assign qualBits = srcIn & enBits & unmaskBits;
  assign irq      = |qualBits;

  // Lowest-numbered qualifying source wins: scan from the top down
  always_comb begin
    winnerId = SPURIOUS_ID;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (qualBits[i]) winnerId = ID_W'(i);
    end
  end

  // R2: an in-range set-enable write leaves the source enabled
  a_r2_enable_set: assert property (@(posedge clk) disable iff (!rstN)
    (stb.enSet && idOk) |=> enBits[$past(idx)]);
  // R3: an in-range clear-enable write leaves the source disabled
  a_r3_enable_clr: assert property (@(posedge clk) disable iff (!rstN)
    (stb.enClr && idOk) |=> !enBits[$past(idx)]);
  // R4: unmask write
  a_r4_unmask: assert property (@(posedge clk) disable iff (!rstN)
    (stb.unmaskSet && idOk) |=> unmaskBits[$past(idx)]);
  // R5: mask write
  a_r5_mask: assert property (@(posedge clk) disable iff (!rstN)
    (stb.maskSet && idOk) |=> !unmaskBits[$past(idx)]);
  // R11: out-of-range numbers change nothing
  a_r11_ignore_id: assert property (@(posedge clk) disable iff (!rstN)
    (anyWr && !idOk) |=> ($stable(enBits) && $stable(unmaskBits)));
  // R12: no strobe means no state change
  a_r12_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !anyWr |=> ($stable(enBits) && $stable(unmaskBits)));

endmodule

// File: rtl/vic_ack_top.sv
module vic_ack_top
  import vic_ack_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               wrEn,
  input  logic [12:0]        wrAddr,
  input  logic [31:0]        wrData,
  input  logic               rdEn,
  input  logic [12:0]        rdAddr,
  output logic               rdValid,
  output logic [31:0]        rdData,
  output logic               irq
);

  ctrlStrobe_t     stb;
  logic [ID_W-1:0] winnerId;

  vic_ack_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .winnerId (winnerId),
    .irqIn    (irq),
    .stb      (stb),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );

  vic_ack_datapath #(.NUM_SRC(NUM_SRC)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .srcIn    (srcIn),
    .stb      (stb),
    .winnerId (winnerId),
    .irq      (irq)
  );

  // R10: a request is raised only when some source is being reported
  a_r10_irq_has_winner: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (winnerId != SPURIOUS_ID));

endmodule

// File: tb/test_vic_ack_top.sv
module test_vic_ack_top;

  localparam int N = 64;
  localparam logic [12:0] A_EN_SET = 13'h0A30;
  localparam logic [12:0] A_EN_CLR = 13'h0A34;
  localparam logic [12:0] A_UNMASK = 13'h10BC;
  localparam logic [12:0] A_MASK   = 13'h10B8;
  localparam logic [12:0] A_ACK    = 13'h10B4;
  localparam logic [12:0] A_NONE   = 13'h0000;
  localparam logic [63:0] B5  = 64'h1 << 5;
  localparam logic [63:0] B9  = 64'h1 << 9;
  localparam logic [63:0] B20 = 64'h1 << 20;
  localparam logic [63:0] B63 = 64'h1 << 63;
  localparam logic [63:0] B0  = 64'h1;

  // {src[63:0], doWr, addr[12:0], id[9:0], expAck[9:0], expIrq}
  localparam int NV = 19;
  localparam logic [98:0] VEC [NV] = '{
    {B5|B9,  1'b0, A_NONE,   10'd0,    10'd1023, 1'b0}, // R7
    {B5|B9,  1'b1, A_EN_SET, 10'd5,    10'd1023, 1'b0}, // R2 masked still
    {B5|B9,  1'b1, A_UNMASK, 10'd5,    10'd5,    1'b1}, // R4 R10
    {B5|B9,  1'b1, A_EN_SET, 10'd9,    10'd5,    1'b1}, // R2
    {B5|B9,  1'b1, A_UNMASK, 10'd9,    10'd5,    1'b1}, // R8
    {B9,     1'b0, A_NONE,   10'd0,    10'd9,    1'b1}, // R8 level drop
    {B9,     1'b1, A_MASK,   10'd9,    10'd1023, 1'b0}, // R5
    {B9,     1'b1, A_UNMASK, 10'd9,    10'd9,    1'b1}, // R4
    {B9,     1'b1, A_EN_CLR, 10'd9,    10'd1023, 1'b0}, // R3
    {B5|B9,  1'b0, A_NONE,   10'd0,    10'd5,    1'b1}, // R10
    {B9,     1'b1, 13'h1A30, 10'd9,    10'd1023, 1'b0}, // R12
    {B20,    1'b1, A_EN_SET, 10'd20,   10'd1023, 1'b0}, // R2
    {B20,    1'b1, 13'h00BC, 10'd20,   10'd1023, 1'b0}, // R12
    {B63,    1'b1, A_UNMASK, 10'd63,   10'd1023, 1'b0}, // R4
    {B63,    1'b1, A_EN_SET, 10'd1023, 10'd1023, 1'b0}, // R11
    {B63,    1'b1, A_EN_SET, 10'd127,  10'd1023, 1'b0}, // R11 alias
    {B63,    1'b1, A_EN_SET, 10'd63,   10'd63,   1'b1}, // R2
    {B0|B63, 1'b1, A_EN_SET, 10'd0,    10'd63,   1'b1}, // R5 source 0 masked
    {B0|B63, 1'b1, A_UNMASK, 10'd0,    10'd0,    1'b1}  // R8
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  srcIn = '0;
  logic          wrEn = 1'b0;
  logic [12:0]   wrAddr = '0;
  logic [31:0]   wrData = '0;
  logic          rdEn = 1'b0;
  logic [12:0]   rdAddr = '0;
  logic          rdValid;
  logic [31:0]   rdData;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [31:0] got;

  always #10 clk = ~clk;

  vic_ack_top #(.NUM_SRC(N)) i_vic_ack_top (
    .clk(clk), .rstN(rstN), .srcIn(srcIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr),
    .rdValid(rdValid), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [12:0] a, input logic [9:0] id);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = {22'h3FFFFF, id};
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    check("R6 rdValid", 32'(rdValid), 32'd1);
    d = rdData;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    srcIn = '1;
    check("R1 irq after reset", 32'(irq), 32'd0);
    check("R1 rdValid after reset", 32'(rdValid), 32'd0);
    rstN = 1'b1;
    doRead(A_ACK, got);
    check("R1 ack after reset", got, 32'd1023);
    check("R1 irq all lines high", 32'(irq), 32'd0);
    @(negedge clk);
    check("R6 rdValid drops", 32'(rdValid), 32'd0);

    for (int v = 0; v < NV; v++) begin
      srcIn = VEC[v][98:35];
      if (VEC[v][34]) doWrite(VEC[v][33:21], VEC[v][20:11]);
      else @(negedge clk);
      check($sformatf("R10 irq vec%0d", v), 32'(irq), 32'(VEC[v][0]));
      doRead(A_ACK, got);
      check($sformatf("R8 ack vec%0d", v), got, 32'(VEC[v][10:1]));
    end

    // R9: acknowledge has no side effect; the same ID returns
    doRead(A_ACK, got);
    check("R9 repeat ack", got, 32'd0);
    doRead(A_ACK, got);
    check("R9 repeat ack again", got, 32'd0);

    // R6: non-ack address reads zero
    doRead(A_UNMASK, got);
    check("R6 other address", got, 32'd0);
    doRead(13'h00B4, got);
    check("R6 ack offset in global region", got, 32'd0);

    // R13: mask source 0 in the same cycle as the ack read
    @(negedge clk);
    wrEn = 1'b1; wrAddr = A_MASK; wrData = 32'd0;
    rdEn = 1'b1; rdAddr = A_ACK;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R13 colliding read sees old state", rdData, 32'd0);
    doRead(A_ACK, got);
    check("R13 next read sees new state", got, 32'd63);

    // R13: unmask source 0 again while 63 is reported
    @(negedge clk);
    wrEn = 1'b1; wrAddr = A_UNMASK; wrData = 32'd0;
    rdEn = 1'b1; rdAddr = A_ACK;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R13 colliding unmask read", rdData, 32'd63);
    doRead(A_ACK, got);
    check("R13 after unmask", got, 32'd0);

    // R7: drop all lines
    srcIn = '0;
    @(negedge clk);
    check("R10 irq with no lines", 32'(irq), 32'd0);
    doRead(A_ACK, got);
    check("R7 spurious with no lines", got, 32'd1023);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule